// File: doc/BRIEF.md
# Display Identification Serial Streamer

This block sends the first 128 bytes of a display-identification memory as an endless serial stream on an open-drain data line. It has no bus protocol and no addressing from outside. Each rising edge of a slow side clock, normally derived from vertical sync, moves the stream on by one bit. The side clock level arrives asynchronously. The block synchronizes it into the system clock domain and detects its rising edges there. The block reads the memory through a plain combinational read port and presents each bit as a pad drive-enable and value pair.

After reset the block stays silent for nine side-clock edges of warm-up. It then sends frames of nine bits: the eight data bits of a byte, most significant bit first, followed by a null bit that leaves the line released. Bytes go out in increasing address order and wrap from the last streamed byte back to byte zero. A mode controller gates the block with an enable signal and can issue a one-cycle restart. Both return the stream to the most significant bit of byte zero, and neither repeats the warm-up.

The memory read is a synchronous pull. One bit is taken in the cycle the side-clock edge is recognized, and the memory cannot hold that edge back. For that reason the read port is a plain address and data pair with no valid/ready handshake. The memory must return data for `mem_addr` combinationally in the same cycle.

Top module: `ddc_stream_tx`

## Requirements
- R1: While reset is asserted and directly after it, `sda_oe` is 0, `sda_o` is 1 and `mem_addr` is 00h.
- R2: While enabled, the first nine recognized rising edges of `vclk_in` after reset leave the line released (`sda_oe`=0, `sda_o`=1).
- R3: The tenth recognized rising edge drives bit 7 of byte 00h. After that, the output changes only in response to a rising edge of `vclk_in`; a falling edge leaves it unchanged.
- R4: Each frame has nine bits. Bits 7 down to 0 of the byte at the current address go first. The ninth bit is a null bit with the line released (`sda_oe`=0, `sda_o`=1). A data bit of 0 gives `sda_oe`=1, `sda_o`=0. A data bit of 1 gives `sda_oe`=0, `sda_o`=1.
- R5: The address rises by one per frame and wraps from 7Fh to 00h. `mem_addr` bit 7 is never 1, so only the lower 128 bytes are ever read.
- R6: `vclk_in` passes through two synchronizer flops before edge detection. The output responds on the third rising edge of `clk` after `vclk_in` rises, and it is unchanged after the second.
- R7: While `stream_en` is 0, the line is released, `mem_addr` is held at 00h, and rising edges of `vclk_in` have no effect.
- R8: After `stream_en` returns to 1, or after a `restart` pulse, the next rising edge drives bit 7 of byte 00h. The warm-up is not repeated.
- R9: If `restart` is high in the same cycle that a rising edge is recognized, the restart wins. That edge leaves the line released, and the following edge drives bit 7 of byte 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vclk_in | input | 1 | Asynchronous side-clock level that paces the stream |
| stream_en | input | 1 | Enable from the mode controller; when low, the block is idle and held at its start point |
| restart | input | 1 | One-cycle request to restart at bit 7 of byte 00h |
| mem_addr | output | 8 | Read address into the memory array |
| mem_rdata | input | 8 | Byte at `mem_addr`, returned combinationally |
| sda_oe | output | 1 | Pad drive enable; 1 pulls the data line low |
| sda_o | output | 1 | Logical bit presented; 1 when the line is released |

## Verification
A restart request and a recognized side-clock edge can arrive in the same system-clock cycle. In that cycle the sequencer could either emit a bit or rewind. The bench provokes the collision by raising `vclk_in` and pulsing `restart` exactly two clock edges later, in the cycle where the synchronized edge is detected. The scoreboard then expects a released line for that edge, and bit 7 of byte 00h on the next edge. A second case checks the frame boundary, where the null bit and the address step land on the same edge. It compares every bit across a full 128-byte wrap against a memory model whose upper half holds different data.

// File: rtl/ddc_stream_pkg.sv
package ddc_stream_pkg;

  // Drive pair handed to the open-drain pad.
  typedef struct packed {
    logic oe;   // 1: pull line low
    logic val;  // logical bit presented
  } pad_drive_t;

  localparam pad_drive_t PAD_RELEASED = '{oe: 1'b0, val: 1'b1};

endpackage

// File: rtl/vclk_edge_sync.sv
module vclk_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vclk_in,
  output logic rise
);
  logic [STAGES-1:0] stg;
  logic              last;

  // Reset to the idle-high level, so a line already high gives no false edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg  <= '1;
      last <= 1'b1;
    end else begin
      stg  <= {stg[STAGES-2:0], vclk_in};
      last <= stg[STAGES-1];
    end
  end

  assign rise = stg[STAGES-1] & ~last;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R3

endmodule

// File: rtl/warmup_gate.sv
module warmup_gate #(
  parameter int WARM_EDGES = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic rise,
  output logic warm_done,
  output logic step
);
  localparam int CW = $clog2(WARM_EDGES + 1);
  localparam logic [CW-1:0] LAST_WARM = CW'(WARM_EDGES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      warm_done <= 1'b0;
    end else if (en && rise && !warm_done) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST_WARM) warm_done <= 1'b1;
    end
  end

  // The edge that ends warm-up is absorbed; later edges pass through.
  assign step = rise & en & warm_done;

  AST_WARM_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    !warm_done |-> (cnt < CW'(WARM_EDGES))); // R2

  AST_WARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    warm_done |=> warm_done); // R8

  AST_WARM_BY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warm_done) |-> $past(rise && en)); // R2

endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer
  import ddc_stream_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PTR_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              restart,
  input  logic              step,
  input  logic [BYTE_W-1:0] rdata,
  output logic [PTR_W-1:0]  ptr,
  output pad_drive_t        drive
);
  localparam int IW = $clog2(BYTE_W + 1);
  localparam logic [IW-1:0] NULL_IDX = IW'(BYTE_W);

  logic [IW-1:0]     bit_idx;
  logic [BYTE_W-1:0] shifted;
  logic              cur_bit;

  always_comb begin
    shifted = rdata << bit_idx;
    cur_bit = shifted[BYTE_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx <= '0;
      ptr     <= '0;
      drive   <= PAD_RELEASED;
    end else if (!en || restart) begin
      bit_idx <= '0;
      ptr     <= '0;
      drive   <= PAD_RELEASED;
    end else if (step) begin
      if (bit_idx == NULL_IDX) begin
        bit_idx <= '0;
        ptr     <= ptr + 1'b1;
        drive   <= PAD_RELEASED;
      end else begin
        bit_idx   <= bit_idx + 1'b1;
        drive.oe  <= ~cur_bit;
        drive.val <= cur_bit;
      end
    end
  end

  AST_NULL_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !restart && step && bit_idx == NULL_IDX) |=> !drive.oe && drive.val); // R4

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !restart && step && bit_idx == NULL_IDX) |=> ptr == $past(ptr) + 1'b1); // R5

  AST_RESTART_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && en) |=> (ptr == '0) && (bit_idx == '0) && !drive.oe); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (ptr == '0) && !drive.oe); // R7

  AST_QUIET_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !restart && !step) |=> $stable(drive) && $stable(ptr)); // R3

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_idx <= NULL_IDX); // R4

endmodule

// File: rtl/ddc_stream_tx.sv
module ddc_stream_tx
  import ddc_stream_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int BYTE_W       = 8,
  parameter int STREAM_BYTES = 128,
  parameter int WARM_EDGES   = 9,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vclk_in,
  input  logic              stream_en,
  input  logic              restart,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              sda_oe,
  output logic              sda_o
);
  localparam int PTR_W = $clog2(STREAM_BYTES);

  logic             rise;
  logic             warm_done;
  logic             step;
  logic [PTR_W-1:0] ptr;
  pad_drive_t       drive;

  vclk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .vclk_in (vclk_in),
    .rise    (rise)
  );

  warmup_gate #(.WARM_EDGES(WARM_EDGES)) u_warm (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (stream_en),
    .rise      (rise),
    .warm_done (warm_done),
    .step      (step)
  );

  frame_sequencer #(.BYTE_W(BYTE_W), .PTR_W(PTR_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (stream_en),
    .restart (restart),
    .step    (step),
    .rdata   (mem_rdata),
    .ptr     (ptr),
    .drive   (drive)
  );

  // The stream window is the low part of the array; the upper address bits stay zero.
  generate
    if (ADDR_W > PTR_W) begin : g_pad_addr
      assign mem_addr = {{(ADDR_W-PTR_W){1'b0}}, ptr};
    end else begin : g_full_addr
      assign mem_addr = ptr[ADDR_W-1:0];
    end
  endgenerate

  assign sda_oe = drive.oe;
  assign sda_o  = drive.val;

  AST_WARM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !warm_done |-> !sda_oe && sda_o); // R2

  AST_ADDR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_addr < ADDR_W'(STREAM_BYTES)); // R5

  AST_PAD_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> !sda_o); // R4

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !stream_en |=> !sda_oe); // R7

endmodule

// File: tb/ddc_stream_tx_tb.sv
module ddc_stream_tx_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vclk_in = 1'b0;
  logic       stream_en = 1'b1;
  logic       restart = 1'b0;
  logic [7:0] mem_addr;
  logic [7:0] mem_rdata;
  logic       sda_oe;
  logic       sda_o;

  int errors = 0;
  int checks = 0;
  int upper_hits = 0;

  typedef struct {
    int    exp;     // 0: pulled low, 1: released
    string tag;
  } exp_item_t;

  exp_item_t sb_q[$];
  event      chk_ev;

  // Bench model state
  int  m_warm = 0;
  int  m_bit  = 0;
  int  m_addr = 0;
  bit  m_en   = 1'b1;

  always #10 clk = ~clk;

  function automatic logic [7:0] mem_fn(input logic [7:0] a);
    return (a * 8'd29 + 8'h5A) ^ {a[2:0], 5'b0} ^ {a[7], 7'b0};
  endfunction

  assign mem_rdata = mem_fn(mem_addr);

  ddc_stream_tx dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .vclk_in   (vclk_in),
    .stream_en (stream_en),
    .restart   (restart),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .sda_oe    (sda_oe),
    .sda_o     (sda_o)
  );

  always @(negedge clk) if (rst_n && mem_addr[7]) upper_hits++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model_step(input bit rst_same);
    logic [7:0] b;
    if (!m_en) return 1;
    if (m_warm < 9) begin
      m_warm++;
      return 1;
    end
    if (rst_same) begin
      m_bit = 0; m_addr = 0;
      return 1;
    end
    if (m_bit == 8) begin
      m_bit = 0;
      m_addr = (m_addr + 1) % 128;
      return 1;
    end
    b = mem_fn(8'(m_addr));
    m_bit++;
    return int'(b[8 - m_bit]);
  endfunction

  // Monitor: pops expected bits and compares them with the pad outputs.
  initial begin
    forever begin
      exp_item_t it;
      @(chk_ev);
      it = sb_q.pop_front();
      check((sda_oe == (it.exp == 0)) && (sda_o == it.exp[0]), it.tag,
            {sda_oe, sda_o}, (it.exp == 0) ? 2 : 1);
    end
  end

  // mode 0: plain pulse, 1: latency probe (R6), 2: restart in the edge cycle (R9)
  task automatic pulse(input int mode, input string tag);
    exp_item_t it;
    logic      oe_before;
    it.exp = model_step(mode == 2);
    it.tag = tag;
    @(negedge clk);
    oe_before = sda_oe;
    vclk_in = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    if (mode == 1) check(sda_oe == oe_before, "R6 unchanged after two edges", sda_oe, oe_before);
    if (mode == 2) restart = 1'b1;
    @(posedge clk);
    @(negedge clk);
    restart = 1'b0;
    if (mode == 1) check(sda_oe == (it.exp == 0), "R6 response on third edge", sda_oe, it.exp == 0);
    repeat (4) @(negedge clk);
    sb_q.push_back(it);
    -> chk_ev;
    #1;
    oe_before = sda_oe;
    vclk_in = 1'b0;
    repeat (6) @(negedge clk);
    check(sda_oe == oe_before, "R3 falling edge has no effect", sda_oe, oe_before);
  endtask

  task automatic do_restart();
    @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    m_bit = 0; m_addr = 0;
    check(mem_addr == 8'h00, "R8 restart rewinds address", mem_addr, 0);
    check(!sda_oe, "R8 restart releases line", sda_oe, 0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!sda_oe && sda_o, "R1 released in reset", {sda_oe, sda_o}, 1);
    check(mem_addr == 8'h00, "R1 address zero in reset", mem_addr, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!sda_oe && sda_o, "R1 released after reset", {sda_oe, sda_o}, 1);

    for (int i = 0; i < 9; i++) pulse(0, "R2 warm-up edge released");
    pulse(1, "R3 tenth edge drives MSB of 00h");
    for (int i = 0; i < 8; i++) pulse(0, "R4 first frame bits");
    for (int i = 0; i < 128 * 9 + 20; i++) pulse(0, "R5 stream across wrap");
    check(upper_hits == 0, "R5 upper half never addressed", upper_hits, 0);

    pulse(0, "R4 mid-frame bit");
    do_restart();
    for (int i = 0; i < 20; i++) pulse(0, "R8 stream after restart");

    pulse(2, "R9 restart wins over same-cycle edge");
    for (int i = 0; i < 20; i++) pulse(0, "R9 stream after collision");

    @(negedge clk);
    stream_en = 1'b0;
    m_en = 1'b0;
    repeat (3) @(negedge clk);
    check(!sda_oe, "R7 disabled line released", sda_oe, 0);
    for (int i = 0; i < 3; i++) begin
      pulse(0, "R7 edge ignored while disabled");
      check(mem_addr == 8'h00, "R7 address held while disabled", mem_addr, 0);
    end
    @(negedge clk);
    stream_en = 1'b1;
    m_en = 1'b1;
    m_bit = 0; m_addr = 0;
    for (int i = 0; i < 20; i++) pulse(0, "R8 stream after re-enable");

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule